// File: doc/BRIEF.md
# Write-Once Snooping Cache Line Controller

This block keeps the coherence state of each line in a small direct-mapped, write-back cache. The cache sits on a shared bus that other caches also watch. A processor issues loads and stores on a valid/ready port. When a request cannot be served from the local line, the controller raises a bus master request carrying one of four commands: read, read-invalidate, invalidate, or write-back. At the same time a snoop port watches the transactions granted to other masters. When another master reads a line that this cache holds modified, the snoop port stops memory from answering and supplies the line itself.

The protocol is write-once. The first store to a clean line that may be shared is written through to memory with an invalidate, and the line becomes reserved. Later stores stay local and make the line dirty. Lines hold one word. An address splits into a tag (upper bits) and a line index (lower `IDX_W` bits).

Back-pressure rules:
- The processor must hold `cpu_valid` and its request fields steady until it sees `cpu_ready` high at a clock edge.
- A bus transaction completes in the single cycle in which `bm_req` and `bm_gnt` are both high. Read data must be presented on `bm_rdata` in that same cycle.
- The arbiter grants at most one master per cycle. It presents the granted transaction to every other master's snoop port in that cycle, and the snoop answer is combinational.
- Once raised, `bm_req` stays high until it is granted. The one exception is a cycle in which a snoop is presented: after that cycle the controller may drop or change its command, because the snoop may have changed the line.

Top module: `wonce_cache_ctrl`

## Requirements
- R1: After reset every line is invalid, and `cpu_ready` and `bm_req` are low. As a result, the first access to any address goes to the bus.
- R2: A load miss raises `bm_req` with command read (`bm_cmd` = 0) at the load address. The word on `bm_rdata` at the grant is stored as a valid line. `cpu_ready` rises in the cycle after the grant, with that word on `cpu_rdata`.
- R3: A load hit completes in the cycle it is presented, with no bus request.
- R4: A store hit on a valid line raises an invalidate (`bm_cmd` = 2) that carries the store address and word, so memory is updated. The line becomes reserved, and the store completes in the cycle after the grant.
- R5: A store hit on a reserved or dirty line completes in the cycle it is presented, with no bus request, and leaves the line dirty.
- R6: A store miss raises a read-invalidate (`bm_cmd` = 1). At the grant the line is filled with the store word and marked dirty.
- R7: Replacing a dirty line first issues a write-back (`bm_cmd` = 3) of the old address and word, which leaves the slot invalid, and then the fill. Replacing a clean line issues no write-back.
- R8: A snooped read that matches a dirty line raises `sn_inhibit` and drives the word on `sn_data`. The bus copies that word to memory, and the line drops to valid, so the next local store to it issues an invalidate.
- R9: A snooped read that matches a reserved line makes it valid, so the next local store issues an invalidate.
- R10: A snooped read-invalidate or invalidate that matches a line makes it invalid, so the next local access to it misses.
- R11: In a cycle with `sn_valid` high, no local hit completes, and the processor side writes no line.
- R12: While a request needs the bus, `cpu_ready` stays low; in particular it is never high in a grant cycle. `bm_req` is held until it is granted, except after a snoop cycle.
- R13: With two controllers on one bus, every load returns the value of the most recent completed store to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_valid | input | 1 | Processor request valid |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | TAG_W+IDX_W | Word address |
| cpu_wdata | input | DATA_W | Store word |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Load word, valid with cpu_ready |
| bm_req | output | 1 | Bus master request |
| bm_cmd | output | 2 | 0 read, 1 read-invalidate, 2 invalidate, 3 write-back |
| bm_addr | output | TAG_W+IDX_W | Transaction address |
| bm_wdata | output | DATA_W | Word for invalidate or write-back |
| bm_gnt | input | 1 | Grant; the transaction completes this cycle |
| bm_rdata | input | DATA_W | Fill word from memory or another cache |
| sn_valid | input | 1 | Another master's transaction is on the bus |
| sn_cmd | input | 2 | Snooped command, same encoding as bm_cmd |
| sn_addr | input | TAG_W+IDX_W | Snooped address |
| sn_inhibit | output | 1 | Stop memory; this cache supplies the word |
| sn_data | output | DATA_W | Supplied word |

## Verification
The embedded assertions check the handshake on every cycle: ready only under a valid request, ready never in a grant cycle, the request held until it is granted, and a write-back always leaving its slot invalid. They also check that the snoop and processor paths never update a line in the same cycle. The state transitions of the four-state protocol cannot be seen at the ports directly. Only the bench scenarios can show them, by the command the next access issues. These scenarios cover a reserved or dirty line dropping to valid under a snooped read, an invalidated line missing again, and a dirty victim being written back before its fill. The claim that the last stored value is always returned is shown only by the two-controller sweep with a memory model.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_VAL = 2'd1,
    LN_RSV = 2'd2,
    LN_DRT = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    BUS_RD  = 2'd0,
    BUS_RDX = 2'd1,
    BUS_INV = 2'd2,
    BUS_WB  = 2'd3
  } bus_cmd_t;
endpackage

// File: rtl/wonce_line_store.sv
module wonce_line_store
  import coh_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  ra_idx,
  output line_st_t          ra_st,
  output logic [TAG_W-1:0]  ra_tag,
  output logic [DATA_W-1:0] ra_data,
  input  logic [IDX_W-1:0]  rb_idx,
  output line_st_t          rb_st,
  output logic [TAG_W-1:0]  rb_tag,
  output logic [DATA_W-1:0] rb_data,
  input  logic              cw_en,
  input  logic [IDX_W-1:0]  cw_idx,
  input  line_st_t          cw_st,
  input  logic [TAG_W-1:0]  cw_tag,
  input  logic [DATA_W-1:0] cw_data,
  input  logic              sw_en,
  input  logic [IDX_W-1:0]  sw_idx,
  input  line_st_t          sw_st
);
  localparam int LINES = 1 << IDX_W;

  line_st_t          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  assign ra_st   = st_q[ra_idx];
  assign ra_tag  = tag_q[ra_idx];
  assign ra_data = data_q[ra_idx];
  assign rb_st   = st_q[rb_idx];
  assign rb_tag  = tag_q[rb_idx];
  assign rb_data = data_q[rb_idx];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[i] <= LN_INV;
      end else if (sw_en && sw_idx == IDX_W'(i)) begin
        st_q[i] <= sw_st;
      end else if (cw_en && cw_idx == IDX_W'(i)) begin
        st_q[i] <= cw_st;
      end
    end

    always_ff @(posedge clk) begin
      if (cw_en && cw_idx == IDX_W'(i)) begin
        tag_q[i]  <= cw_tag;
        data_q[i] <= cw_data;
      end
    end
  end

  // R11
  no_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_en && cw_en));
endmodule

// File: rtl/wonce_snoop.sv
module wonce_snoop
  import coh_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 2,
  parameter int DATA_W = 8,
  localparam int ADDR_W = IDX_W + TAG_W
) (
  input  logic              sn_valid,
  input  logic [1:0]        sn_cmd,
  input  logic [ADDR_W-1:0] sn_addr,
  output logic              sn_inhibit,
  output logic [DATA_W-1:0] sn_data,
  output logic [IDX_W-1:0]  ln_idx,
  input  line_st_t          ln_st,
  input  logic [TAG_W-1:0]  ln_tag,
  input  logic [DATA_W-1:0] ln_data,
  output logic              sw_en,
  output line_st_t          sw_st
);
  logic     match;
  bus_cmd_t cmd;

  assign cmd    = bus_cmd_t'(sn_cmd);
  assign ln_idx = sn_addr[IDX_W-1:0];
  assign match  = sn_valid && (ln_st != LN_INV) && (ln_tag == sn_addr[ADDR_W-1:IDX_W]);

  always_comb begin
    sw_en      = 1'b0;
    sw_st      = ln_st;
    sn_inhibit = 1'b0;
    if (match) begin
      unique case (cmd)
        BUS_RD: begin
          sn_inhibit = (ln_st == LN_DRT);
          if (ln_st == LN_DRT || ln_st == LN_RSV) begin
            sw_en = 1'b1;
            sw_st = LN_VAL;
          end
        end
        BUS_RDX: begin
          sn_inhibit = (ln_st == LN_DRT);
          sw_en      = 1'b1;
          sw_st      = LN_INV;
        end
        BUS_INV: begin
          sw_en = 1'b1;
          sw_st = LN_INV;
        end
        default: ;
      endcase
    end
  end

  assign sn_data = sn_inhibit ? ln_data : '0;
endmodule

// File: rtl/wonce_req_fsm.sv
module wonce_req_fsm
  import coh_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 2,
  parameter int DATA_W = 8,
  localparam int ADDR_W = IDX_W + TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bm_req,
  output bus_cmd_t          bm_cmd,
  output logic [ADDR_W-1:0] bm_addr,
  output logic [DATA_W-1:0] bm_wdata,
  input  logic              bm_gnt,
  input  logic [DATA_W-1:0] bm_rdata,
  input  logic              sn_valid,
  output logic [IDX_W-1:0]  ln_idx,
  input  line_st_t          ln_st,
  input  logic [TAG_W-1:0]  ln_tag,
  input  logic [DATA_W-1:0] ln_data,
  output logic              cw_en,
  output line_st_t          cw_st,
  output logic [TAG_W-1:0]  cw_tag,
  output logic [DATA_W-1:0] cw_data
);
  typedef enum logic {PH_IDLE, PH_DONE} phase_t;
  phase_t phase_q;

  logic [TAG_W-1:0] req_tag;
  logic hit, local_ok, dirty_victim, granted, local_go;

  assign ln_idx       = cpu_addr[IDX_W-1:0];
  assign req_tag      = cpu_addr[ADDR_W-1:IDX_W];
  assign hit          = (ln_st != LN_INV) && (ln_tag == req_tag);
  assign local_ok     = hit && (!cpu_we || ln_st == LN_RSV || ln_st == LN_DRT);
  assign dirty_victim = (ln_st == LN_DRT) && (ln_tag != req_tag);

  always_comb begin
    if (dirty_victim)  bm_cmd = BUS_WB;
    else if (!hit)     bm_cmd = cpu_we ? BUS_RDX : BUS_RD;
    else               bm_cmd = BUS_INV;
  end

  assign bm_req   = (phase_q == PH_IDLE) && cpu_valid && !local_ok;
  assign bm_addr  = dirty_victim ? {ln_tag, ln_idx} : cpu_addr;
  assign bm_wdata = dirty_victim ? ln_data : cpu_wdata;
  assign granted  = bm_req && bm_gnt;
  assign local_go = (phase_q == PH_IDLE) && cpu_valid && local_ok && !sn_valid;

  assign cpu_ready = (phase_q == PH_DONE) || local_go;
  assign cpu_rdata = ln_data;

  always_comb begin
    cw_en   = 1'b0;
    cw_st   = ln_st;
    cw_tag  = req_tag;
    cw_data = cpu_wdata;
    if (granted) begin
      cw_en = 1'b1;
      unique case (bm_cmd)
        BUS_WB: begin
          cw_st   = LN_INV;
          cw_tag  = ln_tag;
          cw_data = ln_data;
        end
        BUS_RD: begin
          cw_st   = LN_VAL;
          cw_data = bm_rdata;
        end
        BUS_RDX: cw_st = LN_DRT;
        default: cw_st = LN_RSV;
      endcase
    end else if (local_go && cpu_we) begin
      cw_en = 1'b1;
      cw_st = LN_DRT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
    end else if (phase_q == PH_DONE) begin
      phase_q <= PH_IDLE;
    end else if (granted && bm_cmd != BUS_WB) begin
      phase_q <= PH_DONE;
    end
  end

  // R12
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_valid);

  // R12
  stall_on_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_req && bm_gnt) |-> !cpu_ready);

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_req && !bm_gnt && !sn_valid) |=> bm_req);

  // R7
  wb_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bm_req && bm_gnt && bm_cmd == BUS_WB) |=> (ln_st == LN_INV));
endmodule

// File: rtl/wonce_cache_ctrl.sv
module wonce_cache_ctrl
  import coh_pkg::*;
#(
  parameter int IDX_W  = 2,
  parameter int TAG_W  = 2,
  parameter int DATA_W = 8,
  localparam int ADDR_W = IDX_W + TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bm_req,
  output logic [1:0]        bm_cmd,
  output logic [ADDR_W-1:0] bm_addr,
  output logic [DATA_W-1:0] bm_wdata,
  input  logic              bm_gnt,
  input  logic [DATA_W-1:0] bm_rdata,
  input  logic              sn_valid,
  input  logic [1:0]        sn_cmd,
  input  logic [ADDR_W-1:0] sn_addr,
  output logic              sn_inhibit,
  output logic [DATA_W-1:0] sn_data
);
  bus_cmd_t          cmd_e;
  logic [IDX_W-1:0]  a_idx, b_idx;
  line_st_t          a_st, b_st, cw_st, sw_st;
  logic [TAG_W-1:0]  a_tag, b_tag, cw_tag;
  logic [DATA_W-1:0] a_data, b_data, cw_data;
  logic              cw_en, sw_en;

  assign bm_cmd = cmd_e;

  wonce_req_fsm #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .bm_req(bm_req), .bm_cmd(cmd_e), .bm_addr(bm_addr), .bm_wdata(bm_wdata),
    .bm_gnt(bm_gnt), .bm_rdata(bm_rdata), .sn_valid(sn_valid),
    .ln_idx(a_idx), .ln_st(a_st), .ln_tag(a_tag), .ln_data(a_data),
    .cw_en(cw_en), .cw_st(cw_st), .cw_tag(cw_tag), .cw_data(cw_data)
  );

  wonce_snoop #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_snp (
    .sn_valid(sn_valid), .sn_cmd(sn_cmd), .sn_addr(sn_addr),
    .sn_inhibit(sn_inhibit), .sn_data(sn_data),
    .ln_idx(b_idx), .ln_st(b_st), .ln_tag(b_tag), .ln_data(b_data),
    .sw_en(sw_en), .sw_st(sw_st)
  );

  wonce_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(a_idx), .ra_st(a_st), .ra_tag(a_tag), .ra_data(a_data),
    .rb_idx(b_idx), .rb_st(b_st), .rb_tag(b_tag), .rb_data(b_data),
    .cw_en(cw_en), .cw_idx(a_idx), .cw_st(cw_st), .cw_tag(cw_tag), .cw_data(cw_data),
    .sw_en(sw_en), .sw_idx(b_idx), .sw_st(sw_st)
  );
endmodule

// File: tb/wonce_cache_ctrl_test.sv
`timescale 1ns/1ps
module wonce_cache_ctrl_test;
  localparam int AW = 4;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0]    cv, cw, cr, breq, bgnt, inh;
  logic [AW-1:0] ca [2];
  logic [DW-1:0] cd [2];
  logic [DW-1:0] crd [2];
  logic [1:0]    bcmd [2];
  logic [AW-1:0] badr [2];
  logic [DW-1:0] bwd [2];
  logic [DW-1:0] brd [2];
  logic [DW-1:0] sdat [2];

  logic [DW-1:0] mem [16];
  logic [DW-1:0] gold [16];
  logic turn;
  int ncmd [2][4];
  int ninh;
  logic [AW-1:0] wb_adr [2];
  logic [DW-1:0] wb_dat [2];
  int checks = 0, errors = 0, cyc = 0;

  assign bgnt[0] = breq[0] && (!breq[1] || !turn);
  assign bgnt[1] = breq[1] && !bgnt[0];
  assign brd[0]  = inh[1] ? sdat[1] : mem[badr[0]];
  assign brd[1]  = inh[0] ? sdat[0] : mem[badr[1]];

  wonce_cache_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cv[0]), .cpu_we(cw[0]), .cpu_addr(ca[0]), .cpu_wdata(cd[0]),
    .cpu_ready(cr[0]), .cpu_rdata(crd[0]),
    .bm_req(breq[0]), .bm_cmd(bcmd[0]), .bm_addr(badr[0]), .bm_wdata(bwd[0]),
    .bm_gnt(bgnt[0]), .bm_rdata(brd[0]),
    .sn_valid(bgnt[1]), .sn_cmd(bcmd[1]), .sn_addr(badr[1]),
    .sn_inhibit(inh[0]), .sn_data(sdat[0])
  );

  wonce_cache_ctrl peer (
    .clk(clk), .rst_n(rst_n),
    .cpu_valid(cv[1]), .cpu_we(cw[1]), .cpu_addr(ca[1]), .cpu_wdata(cd[1]),
    .cpu_ready(cr[1]), .cpu_rdata(crd[1]),
    .bm_req(breq[1]), .bm_cmd(bcmd[1]), .bm_addr(badr[1]), .bm_wdata(bwd[1]),
    .bm_gnt(bgnt[1]), .bm_rdata(brd[1]),
    .sn_valid(bgnt[0]), .sn_cmd(bcmd[0]), .sn_addr(badr[0]),
    .sn_inhibit(inh[1]), .sn_data(sdat[1])
  );

  function automatic logic [DW-1:0] init_val(input int a);
    return DW'(a * 7 + 3);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= init_val(i);
      turn <= 1'b0;
      ninh <= 0;
      for (int p = 0; p < 2; p++) for (int k = 0; k < 4; k++) ncmd[p][k] <= 0;
    end else begin
      for (int p = 0; p < 2; p++) begin
        if (bgnt[p]) begin
          ncmd[p][bcmd[p]] <= ncmd[p][bcmd[p]] + 1;
          if (inh[1-p]) ninh <= ninh + 1;
          if (bcmd[p] == 2'd0 && inh[1-p]) mem[badr[p]] <= sdat[1-p];
          if (bcmd[p] == 2'd2 || bcmd[p] == 2'd3) mem[badr[p]] <= bwd[p];
          if (bcmd[p] == 2'd3) begin
            wb_adr[p] <= badr[p];
            wb_dat[p] <= bwd[p];
          end
        end
      end
      if (bgnt[0]) turn <= 1'b1;
      else if (bgnt[1]) turn <= 1'b0;
    end
  end

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic op(input int p, input bit we, input logic [AW-1:0] a,
                    input logic [DW-1:0] d, output logic [DW-1:0] rd, output int n);
    @(negedge clk);
    cv[p] = 1'b1; cw[p] = we; ca[p] = a; cd[p] = d; n = 0;
    #1;
    while (!cr[p] && n < 40) begin
      @(negedge clk); #1; n++;
    end
    rd = crd[p];
    @(negedge clk);
    cv[p] = 1'b0;
    if (we) gold[a] = d;
  endtask

  logic [DW-1:0] r0, r1;
  int n0, n1, snap, snap2, snapi;

  initial begin
    cv = '0; cw = '0;
    for (int p = 0; p < 2; p++) begin ca[p] = '0; cd[p] = '0; end
    for (int i = 0; i < 16; i++) gold[i] = init_val(i);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;
    chk(cr[0] == 1'b0, "R1 ready after reset", cr[0], 0);
    chk(breq[0] == 1'b0, "R1 request after reset", breq[0], 0);

    snap = ncmd[0][0];
    op(0, 0, 4'd5, 8'h00, r0, n0);
    chk(r0 == init_val(5), "R2 miss data", r0, init_val(5));
    chk(ncmd[0][0] == snap + 1, "R2 read issued", ncmd[0][0], snap + 1);
    chk(n0 == 1, "R2 ready cycle after grant", n0, 1);

    snap = ncmd[0][0] + ncmd[0][1] + ncmd[0][2] + ncmd[0][3];
    op(0, 0, 4'd5, 8'h00, r0, n0);
    chk(n0 == 0 && r0 == init_val(5), "R3 hit immediate", n0, 0);
    chk(ncmd[0][0] + ncmd[0][1] + ncmd[0][2] + ncmd[0][3] == snap, "R3 no bus", 1, 0);

    op(1, 0, 4'd5, 8'h00, r1, n1);
    snap = ncmd[0][2];
    op(0, 1, 4'd5, 8'hA1, r0, n0);
    chk(ncmd[0][2] == snap + 1, "R4 invalidate issued", ncmd[0][2], snap + 1);
    chk(mem[5] == 8'hA1, "R4 write through", mem[5], 8'hA1);
    chk(n0 == 1, "R4 done after grant", n0, 1);

    snap = ncmd[1][0]; snapi = ninh;
    op(1, 0, 4'd5, 8'h00, r1, n1);
    chk(ncmd[1][0] == snap + 1 && r1 == 8'hA1, "R10 peer copy invalidated", r1, 8'hA1);
    chk(ninh == snapi, "R9 reserved line does not inhibit", ninh, snapi);

    snap = ncmd[0][2];
    op(0, 1, 4'd5, 8'hA2, r0, n0);
    chk(ncmd[0][2] == snap + 1, "R9 reserved demoted to valid", ncmd[0][2], snap + 1);
    snap = ncmd[0][0] + ncmd[0][1] + ncmd[0][2] + ncmd[0][3];
    op(0, 1, 4'd5, 8'hA3, r0, n0);
    chk(n0 == 0 && ncmd[0][0] + ncmd[0][1] + ncmd[0][2] + ncmd[0][3] == snap,
        "R5 local second write", n0, 0);
    snapi = ninh;
    op(1, 0, 4'd5, 8'h00, r1, n1);
    chk(ninh == snapi + 1, "R8 dirty inhibits", ninh, snapi + 1);
    chk(r1 == 8'hA3, "R8 supplied word", r1, 8'hA3);
    chk(mem[5] == 8'hA3, "R8 memory updated", mem[5], 8'hA3);
    snap = ncmd[0][2];
    op(0, 1, 4'd5, 8'hA4, r0, n0);
    chk(ncmd[0][2] == snap + 1, "R8 dirty demoted to valid", ncmd[0][2], snap + 1);

    snap = ncmd[0][1];
    op(0, 1, 4'd9, 8'hB1, r0, n0);
    chk(ncmd[0][1] == snap + 1, "R6 read-invalidate issued", ncmd[0][1], snap + 1);
    snap = ncmd[0][0] + ncmd[0][1] + ncmd[0][2] + ncmd[0][3];
    op(0, 1, 4'd9, 8'hB2, r0, n0);
    chk(n0 == 0 && ncmd[0][0] + ncmd[0][1] + ncmd[0][2] + ncmd[0][3] == snap,
        "R6 line dirty after fill", n0, 0);
    snap = ncmd[0][3]; snap2 = ncmd[0][0];
    op(0, 0, 4'd13, 8'h00, r0, n0);
    chk(ncmd[0][3] == snap + 1, "R7 dirty victim written back", ncmd[0][3], snap + 1);
    chk(wb_adr[0] == 4'd9 && wb_dat[0] == 8'hB2, "R7 write-back word", wb_dat[0], 8'hB2);
    chk(ncmd[0][0] == snap2 + 1 && r0 == init_val(13), "R7 fill after write-back", r0, init_val(13));
    snap = ncmd[0][3];
    op(0, 0, 4'd1, 8'h00, r0, n0);
    chk(ncmd[0][3] == snap && r0 == init_val(1), "R7 clean victim no write-back", ncmd[0][3], snap);

    op(1, 1, 4'd1, 8'hC1, r1, n1);
    snap = ncmd[0][0]; snapi = ninh;
    op(0, 0, 4'd1, 8'h00, r0, n0);
    chk(ncmd[0][0] == snap + 1, "R10 snooped read-invalidate", ncmd[0][0], snap + 1);
    chk(ninh == snapi + 1 && r0 == 8'hC1, "R8 remote dirty supplies", r0, 8'hC1);

    fork
      op(1, 1, 4'd2, 8'hC2, r1, n1);
      op(0, 0, 4'd1, 8'h00, r0, n0);
    join
    chk(n0 == 1 && r0 == 8'hC1, "R11 snoop delays local hit", n0, 1);

    fork
      op(0, 0, 4'd6, 8'h00, r0, n0);
      op(1, 0, 4'd7, 8'h00, r1, n1);
    join
    chk(n0 + n1 == 3 && (n0 == 1 || n1 == 1), "R12 loser stalls", n0 + n1, 3);
    chk(r0 == init_val(6) && r1 == init_val(7), "R12 contended data", r0, init_val(6));

    begin
      logic [15:0] lf;
      lf = 16'hACE1;
      for (int s = 0; s < 600; s++) begin
        logic [AW-1:0] a;
        int p;
        bit we;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        a = lf[3:0]; p = int'(lf[4]); we = (lf[7:5] < 3'd3);
        if (s % 4 == 3) begin
          logic [AW-1:0] a2;
          a2 = a ^ 4'h8;
          fork
            op(p, 1'b1, a, lf[15:8], r0, n0);
            op(1 - p, 1'b0, a2, 8'h00, r1, n1);
          join
          chk(r1 == gold[a2], "R13 concurrent read", r1, gold[a2]);
        end else begin
          op(p, we, a, lf[15:8], r0, n0);
          if (!we) chk(r0 == gold[a], "R13 last written value", r0, gold[a]);
        end
      end
      for (int i = 0; i < 16; i++) begin
        op(i % 2, 1'b0, AW'(i), 8'h00, r0, n0);
        chk(r0 == gold[i], "R13 final readback", r0, gold[i]);
      end
    end

    summary();
  end
endmodule